// File: doc/BRIEF.md
# Serial Input Interrupt Detector

This block watches a bank of input bits that a serial shift engine refreshes once per frame, and turns selected changes or levels on those bits into interrupt events. Each new frame is qualified by a strobe. Every bit has its own trigger class (edge or level), polarity and a dual-edge override, so a single bank can mix rising-edge, falling-edge, both-edge, high-level and low-level sources.

Detected events latch into a per-bit status register. Software clears the register by writing ones to it. A per-bit enable decides which latched bits may drive the single registered interrupt line. Configuration and status go through a small word-wide register port. Reads return data one cycle after the address is presented.

Top module: `serin_irq_detect`

## Requirements
- R1: After synchronous reset, the enable, polarity, class, dual-edge and status registers all read 0, `irq_out` is 0 and the stored previous frame is 0.
- R2: With class bit 0, dual bit 0 and polarity bit 0, a status bit sets when that input goes from 1 in the previous accepted frame to 0 in the new one. This is also the reset configuration.
- R3: With class 0, dual 0 and polarity 1, a status bit sets on a 0-to-1 change between accepted frames.
- R4: With class 0 and dual 1, a status bit sets on any change between accepted frames, whatever the polarity bit holds.
- R5: With class 1, a status bit sets on an accepted frame whose input equals the polarity bit (1 means high, 0 means low). The dual bit has no effect in this case.
- R6: A level-triggered bit sets again on every accepted frame while its level holds, including the first frame after software has cleared it.
- R7: Events come only from cycles with `frame_vld` high. On other cycles `frame_in` is ignored and the stored previous frame keeps its value.
- R8: Writing to status (offset 0x10) clears every bit written as 1 and leaves bits written as 0 unchanged. If a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R9: Status bits latch whether or not they are enabled. `irq_out` is the registered OR of status AND enable, and it follows status by one cycle.
- R10: The register map is enable 0x00, polarity 0x04, class 0x08, dual-edge 0x0C and status 0x10. Each read returns the addressed value on `reg_rdata` one cycle later. Reads of other offsets return 0, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | Strobe marking a fresh input frame |
| frame_in | input | 32 | Sampled input bits of the frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
A frame strobed before clock edge k updates status at edge k. A read issued on the next cycle shows that status at edge k+1, and `irq_out` reflects it at the same edge k+1. A register write at edge e changes `irq_out` at edge e+1. The driver tasks push each expected value into a queue as they issue the read or interrupt probe. The monitor pops and compares that value one time unit after the edge where the result is due, so every comparison lands on the cycle the pipeline depth predicts.

// File: rtl/sgid_pkg.sv
package sgid_pkg;
  localparam int ADDR_W = 5;
  typedef enum logic [ADDR_W-1:0] {
    OFS_EN   = 5'h00,
    OFS_POL  = 5'h04,
    OFS_CLS  = 5'h08,
    OFS_DUAL = 5'h0C,
    OFS_STAT = 5'h10
  } reg_ofs_e;
endpackage

// File: rtl/sgid_cfg_regs.sv
module sgid_cfg_regs
  import sgid_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      cls_q,
  output logic [W-1:0]      dual_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pol_q  <= '0;
      cls_q  <= '0;
      dual_q <= '0;
    end else if (wr) begin
      case (addr)
        OFS_EN:   en_q   <= wdata;
        OFS_POL:  pol_q  <= wdata;
        OFS_CLS:  cls_q  <= wdata;
        OFS_DUAL: dual_q <= wdata;
        default: ;
      endcase
    end
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr || !(addr inside {OFS_EN, OFS_POL, OFS_CLS, OFS_DUAL}))
      |=> $stable({en_q, pol_q, cls_q, dual_q}));
endmodule

// File: rtl/sgid_trig.sv
module sgid_trig #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_vld,
  input  logic [W-1:0] frame_in,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] cls,
  input  logic [W-1:0] dual,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst)            prev_q <= '0;
    else if (frame_vld) prev_q <= frame_in;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rise, fall, edge_hit, lvl_hit;
    always_comb begin
      rise     = frame_in[i] & ~prev_q[i];
      fall     = ~frame_in[i] & prev_q[i];
      edge_hit = dual[i] ? (rise | fall) : (pol[i] ? rise : fall);
      lvl_hit  = (frame_in[i] == pol[i]);
      hit[i]   = frame_vld & (cls[i] ? lvl_hit : edge_hit);
    end
  end

  // R7
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_vld |-> (hit == '0));

  // R7
  prev_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_vld |=> $stable(prev_q));

  // R2 R3 R4
  steady_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && frame_in == prev_q) |-> ((hit & ~cls) == '0));
endmodule

// File: rtl/sgid_status.sv
module sgid_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr) | hit;
  end

  // R8
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(clr & ~hit)) == '0));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~stat_q & $past(hit)) == '0));
endmodule

// File: rtl/serin_irq_detect.sv
module serin_irq_detect
  import sgid_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_vld,
  input  logic [W-1:0]      frame_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              irq_out
);
  logic [W-1:0] en_q, pol_q, cls_q, dual_q, hit, stat_q, clr;

  sgid_cfg_regs #(.W(W)) u_cfg (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .en_q(en_q), .pol_q(pol_q), .cls_q(cls_q), .dual_q(dual_q)
  );

  sgid_trig #(.W(W)) u_trig (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame_in(frame_in),
    .pol(pol_q), .cls(cls_q), .dual(dual_q), .hit(hit)
  );

  assign clr = (reg_wr && reg_addr == OFS_STAT) ? reg_wdata : '0;

  sgid_status #(.W(W)) u_stat (
    .clk(clk), .rst(rst), .hit(hit), .clr(clr), .stat_q(stat_q)
  );

  logic [W-1:0] rd_mux;
  always_comb begin
    case (reg_addr)
      OFS_EN:   rd_mux = en_q;
      OFS_POL:  rd_mux = pol_q;
      OFS_CLS:  rd_mux = cls_q;
      OFS_DUAL: rd_mux = dual_q;
      OFS_STAT: rd_mux = stat_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq_out   <= |(stat_q & en_q);
    end
  end

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(stat_q & en_q) != '0));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_addr inside {OFS_EN, OFS_POL, OFS_CLS, OFS_DUAL, OFS_STAT})
      |=> (reg_rdata == '0));
endmodule

// File: tb/tb_serin_irq_detect.sv
module tb_serin_irq_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_vld = 1'b0;
  logic [31:0] frame_in = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];
  bit          arm = 0;

  always #2 clk = ~clk;

  serin_irq_detect dut (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame_in(frame_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // monitor: one time unit after the edge where the item is due
  always @(posedge clk) begin
    #1;
    if (arm) begin
      logic [31:0] e, a;
      bit k;
      string t;
      e = exp_q.pop_front();
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      a = k ? {31'd0, irq_out} : reg_rdata;
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
      arm = 0;
    end
  end

  task automatic exp_rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
    arm = 1;
    @(negedge clk);
  endtask

  task automatic exp_irq(input bit e, input string t);
    @(negedge clk);
    exp_q.push_back({31'd0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
    arm = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic frame(input logic [31:0] v);
    @(negedge clk);
    frame_vld = 1; frame_in = v;
    @(negedge clk);
    frame_vld = 0;
  endtask

  task automatic frame_and_clear(input logic [31:0] v, input logic [31:0] c);
    @(negedge clk);
    frame_vld = 1; frame_in = v;
    reg_wr = 1; reg_addr = 5'h10; reg_wdata = c;
    @(negedge clk);
    frame_vld = 0; reg_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    exp_rd(5'h00, 32'h0, "R1 enable");
    exp_rd(5'h04, 32'h0, "R1 polarity");
    exp_rd(5'h08, 32'h0, "R1 class");
    exp_rd(5'h0C, 32'h0, "R1 dual");
    exp_rd(5'h10, 32'h0, "R1 status");
    exp_irq(1'b0, "R1 irq");
    // R2 default falling edge; rising on bits 0-7 ignored
    frame(32'h0000_00FF);
    exp_rd(5'h10, 32'h0, "R2 rise ignored");
    frame(32'h0000_000F);
    exp_rd(5'h10, 32'h0000_00F0, "R2 falling");
    exp_irq(1'b0, "R9 disabled no irq");
    wr(5'h00, 32'h0000_0010);
    exp_irq(1'b1, "R9 enabled irq");
    wr(5'h10, 32'h0000_0010);
    exp_irq(1'b0, "R9 irq drops after clear");
    exp_rd(5'h10, 32'h0000_00E0, "R8 w1c");
    wr(5'h10, 32'h0);
    exp_rd(5'h10, 32'h0000_00E0, "R8 zero write");
    wr(5'h10, 32'hFFFF_FFFF);
    exp_rd(5'h10, 32'h0, "R8 clear all");
    // R3 rising
    wr(5'h04, 32'h0000_FF00);
    exp_rd(5'h04, 32'h0000_FF00, "R10 polarity readback");
    frame(32'h0000_0F00);
    exp_rd(5'h10, 32'h0000_0F0F, "R3 rising and falling mix");
    wr(5'h10, 32'hFFFF_FFFF);
    // R4 both edges, polarity ignored
    wr(5'h0C, 32'h00FF_0000);
    wr(5'h04, 32'h00F0_FF00);
    frame(32'h00FF_0F00);
    exp_rd(5'h10, 32'h00FF_0000, "R4 both rising");
    wr(5'h10, 32'hFFFF_FFFF);
    frame(32'h000F_0F00);
    exp_rd(5'h10, 32'h00F0_0000, "R4 both falling");
    wr(5'h10, 32'hFFFF_FFFF);
    // R5 levels
    wr(5'h0C, 32'h0400_0000);
    wr(5'h04, 32'h0300_0000);
    wr(5'h08, 32'h0F00_0000);
    exp_rd(5'h08, 32'h0F00_0000, "R10 class readback");
    frame(32'h0100_0000);
    exp_rd(5'h10, 32'h0D0F_0F00, "R5 level high/low");
    wr(5'h10, 32'hFFFF_FFFF);
    exp_rd(5'h10, 32'h0, "R6 cleared");
    frame(32'h0100_0000);
    exp_rd(5'h10, 32'h0D00_0000, "R6 level resets");
    frame_and_clear(32'h0100_0000, 32'hFFFF_FFFF);
    exp_rd(5'h10, 32'h0D00_0000, "R8 set wins over clear");
    exp_irq(1'b0, "R9 status not enabled");
    // R7 frame strobe gating
    wr(5'h08, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h0C, 32'h0);
    wr(5'h10, 32'hFFFF_FFFF);
    @(negedge clk); frame_in = 32'h0;
    @(negedge clk); @(negedge clk);
    exp_rd(5'h10, 32'h0, "R7 unstrobed ignored");
    frame(32'h0100_0000);
    exp_rd(5'h10, 32'h0, "R7 prev kept");
    frame(32'h0);
    exp_rd(5'h10, 32'h0100_0000, "R7 strobed fall");
    // R10 unmapped
    wr(5'h14, 32'hFFFF_FFFF);
    exp_rd(5'h14, 32'h0, "R10 unmapped read");
    exp_rd(5'h00, 32'h0000_0010, "R10 enable unchanged");
    exp_rd(5'h10, 32'h0100_0000, "R10 status unchanged");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule